// File: doc/BRIEF.md
# Logarithmic Barrel Shifter

This block shifts a data word by any distance from zero to one less than its width in a single combinational pass. The shift is built from a chain of multiplexer stages, one per bit of the shift amount, and stage *i* moves the word by 2^i positions whenever its control bit is set. Only a left-shifting chain exists in hardware. A right shift mirrors the word end-for-end before the chain and mirrors the result again after it, so one chain serves both directions.

Three shift flavours come from two control pins: logical left, logical right and arithmetic right. They differ only in the bit that enters the vacated positions. Arithmetic right feeds in copies of the original most significant bit, and every other combination feeds in zeros. The block has no clock and no storage. The word width is a parameter that must be a power of two, and the width of the amount input follows from it.

Top module: `bshift_log_top`

## Requirements
- R1: With `dir_left` = 1 and `mode_logical` = 1, `data_out` equals `data_in` moved toward the most significant end by `amount` places, and the lowest `amount` bits are 0.
- R2: Bit k of `amount` alone contributes a move of 2^k places, so the total move is the binary value of `amount` (for example 31 moves by 31 places and 16 moves by 16 places).
- R3: With `dir_left` = 0 and `mode_logical` = 1, `data_out` equals `data_in` moved toward the least significant end by `amount` places, and the top `amount` bits are 0.
- R4: With `dir_left` = 0 and `mode_logical` = 0, the move is toward the least significant end, and the top `amount` bits are copies of `data_in[31]`.
- R5: When `amount` = 0, `data_out` equals `data_in` for all four settings of `dir_left` and `mode_logical`.
- R6: With `dir_left` = 1 and `mode_logical` = 0, the result is identical to a logical left move, and the vacated low bits are 0.
- R7: `data_out` follows its inputs with no clock edge in between. It depends on the present inputs only, and a run of earlier inputs leaves no trace in it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 32 | Word to be shifted |
| amount | input | 5 | Shift distance, 0 to 31 |
| dir_left | input | 1 | 1 = move toward the MSB, 0 = move toward the LSB |
| mode_logical | input | 1 | 1 = zero fill, 0 = sign fill on right moves |
| data_out | output | 32 | Shifted word |

## Verification
The checks assume that every input holds a defined 0 or 1 and stays steady while the output settles. They also assume that `amount` is read as an unsigned count below the word width. The bench changes inputs only on the falling edge of its own timing clock and compares the output a short delay later, so each check sees a stable combinational result. Amounts are swept over all 32 legal values, and data patterns are chosen with the top bit both set and clear, so that the sign-fill checks and the zero-fill checks are both triggered.

// File: rtl/bshift_pkg.sv
`timescale 1ns/1ps
package bshift_pkg;

  // Selects the value fed into vacated positions.
  // Sign copy only for a right move in arithmetic mode.
  function automatic logic pick_fill(input logic to_left,
                                     input logic zero_fill,
                                     input logic top_bit);
    logic f;
    if (!to_left && !zero_fill) f = top_bit;
    else                        f = 1'b0;
    return f;
  endfunction

  // Tree input/output steering: left moves use the word as is.
  function automatic logic use_direct(input logic to_left);
    return to_left;
  endfunction

endpackage

// File: rtl/bshift_reverse.sv
`timescale 1ns/1ps
module bshift_reverse #(
  parameter int W = 32
) (
  input  logic [W-1:0] fwd,
  output logic [W-1:0] bwd
);
  for (genvar j = 0; j < W; j++) begin : g_mirror
    assign bwd[j] = fwd[W-1-j];
  end
endmodule

// File: rtl/bshift_stage.sv
`timescale 1ns/1ps
module bshift_stage #(
  parameter int W    = 32,
  parameter int DIST = 1
) (
  input  logic [W-1:0] din,
  input  logic         en,
  input  logic         fill,
  output logic [W-1:0] dout
);
  for (genvar j = 0; j < W; j++) begin : g_bit
    if (j >= DIST) begin : g_take
      assign dout[j] = en ? din[j-DIST] : din[j];
    end else begin : g_fill
      assign dout[j] = en ? fill : din[j];
    end
  end
endmodule

// File: rtl/bshift_tree.sv
`timescale 1ns/1ps
module bshift_tree #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input  logic [W-1:0]        tree_in,
  input  logic [SW-1:0]       amount,
  input  logic                fill,
  output logic [W-1:0]        tree_out,
  output logic [(SW+1)*W-1:0] stage_flat
);
  logic [SW:0][W-1:0] bus;

  assign bus[0] = tree_in;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    bshift_stage #(.W(W), .DIST(1 << i)) stage_i (
      .din (bus[i]),
      .en  (amount[i]),
      .fill(fill),
      .dout(bus[i+1])
    );
  end

  assign tree_out   = bus[SW];
  assign stage_flat = bus;
endmodule

// File: rtl/bshift_log_top.sv
`timescale 1ns/1ps
module bshift_log_top #(
  parameter  int W  = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  data_in,
  input  logic [SW-1:0] amount,
  input  logic          dir_left,
  input  logic          mode_logical,
  output logic [W-1:0]  data_out
);
  import bshift_pkg::*;

  logic [W-1:0]        rev_in;
  logic [W-1:0]        tree_in;
  logic [W-1:0]        tree_out;
  logic [W-1:0]        rev_out;
  logic                fill_bit;
  logic [(SW+1)*W-1:0] stage_flat;

  bshift_reverse #(.W(W)) rev_in_i (.fwd(data_in), .bwd(rev_in));

  assign fill_bit = pick_fill(dir_left, mode_logical, data_in[W-1]);
  assign tree_in  = use_direct(dir_left) ? data_in : rev_in;

  bshift_tree #(.W(W), .SW(SW)) tree_i (
    .tree_in   (tree_in),
    .amount    (amount),
    .fill      (fill_bit),
    .tree_out  (tree_out),
    .stage_flat(stage_flat)
  );

  bshift_reverse #(.W(W)) rev_out_i (.fwd(tree_out), .bwd(rev_out));

  assign data_out = use_direct(dir_left) ? tree_out : rev_out;
endmodule

// File: rtl/bshift_log_chk.sv
`timescale 1ns/1ps
module bshift_log_chk #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input logic [W-1:0]        data_in,
  input logic [SW-1:0]       amount,
  input logic                dir_left,
  input logic                mode_logical,
  input logic [W-1:0]        data_out,
  input logic                fill_bit,
  input logic [(SW+1)*W-1:0] stage_flat
);
  logic [W-1:0] low_mask;
  logic [W-1:0] high_mask;

  always_comb begin
    low_mask  = ~({W{1'b1}} << amount);
    high_mask = ~({W{1'b1}} >> amount);
  end

  always_comb begin
    // R5: zero distance is a pass-through
    if (amount == '0)
      p_zero_pass_r5: assert (data_out == data_in)
        else $error("zero amount changed data");
    // R1 / R6: left moves leave zeros at the bottom
    if (dir_left)
      p_left_low_zero_r1: assert ((data_out & low_mask) == '0)
        else $error("left move low bits not zero");
    // R6: left never uses sign fill
    if (dir_left)
      p_left_fill_zero_r6: assert (fill_bit == 1'b0)
        else $error("left move fill not zero");
    // R3: logical right clears the top
    if (!dir_left && mode_logical)
      p_right_zero_top_r3: assert ((data_out & high_mask) == '0)
        else $error("logical right top bits not zero");
    // R4: arithmetic right copies the sign into the top
    if (!dir_left && !mode_logical && data_in[W-1])
      p_right_sign_top_r4: assert ((data_out & high_mask) == high_mask)
        else $error("arithmetic right top bits not sign");
  end

  // R2: a stage whose control bit is low leaves the word untouched
  for (genvar i = 0; i < SW; i++) begin : g_pass
    always_comb begin
      if (!amount[i])
        p_stage_pass_r2: assert (stage_flat[(i+1)*W +: W] == stage_flat[i*W +: W])
          else $error("idle stage altered data");
    end
  end
endmodule

bind bshift_log_top bshift_log_chk #(.W(W), .SW(SW)) chk_i (
  .data_in     (data_in),
  .amount      (amount),
  .dir_left    (dir_left),
  .mode_logical(mode_logical),
  .data_out    (data_out),
  .fill_bit    (fill_bit),
  .stage_flat  (stage_flat)
);

// File: tb/bshift_log_top_tb_top.sv
`timescale 1ns/1ps
module bshift_log_top_tb_top;
  localparam int W  = 32;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic [W-1:0]  data_in = '0;
  logic [SW-1:0] amount = '0;
  logic          dir_left = 1'b0;
  logic          mode_logical = 1'b0;
  logic [W-1:0]  data_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bshift_log_top #(.W(W)) dut_i (
    .data_in(data_in), .amount(amount), .dir_left(dir_left),
    .mode_logical(mode_logical), .data_out(data_out)
  );

  typedef struct packed {
    logic [W-1:0]  din;
    logic [SW-1:0] amt;
    logic          lft;
    logic          lgc;
    logic [W-1:0]  exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0001, 5'd4,  1'b1, 1'b1, 32'h0000_0010, 4'd1},
    '{32'h8000_0000, 5'd31, 1'b0, 1'b1, 32'h0000_0001, 4'd3},
    '{32'h8000_0000, 5'd31, 1'b0, 1'b0, 32'hFFFF_FFFF, 4'd4},
    '{32'h8000_0000, 5'd4,  1'b0, 1'b0, 32'hF800_0000, 4'd4},
    '{32'hF000_000F, 5'd4,  1'b1, 1'b0, 32'h0000_00F0, 4'd6},
    '{32'h1234_5678, 5'd0,  1'b0, 1'b0, 32'h1234_5678, 4'd5},
    '{32'h1234_5678, 5'd8,  1'b0, 1'b1, 32'h0012_3456, 4'd3},
    '{32'h1234_5678, 5'd16, 1'b1, 1'b1, 32'h5678_0000, 4'd2},
    '{32'h7FFF_FFFF, 5'd1,  1'b0, 1'b0, 32'h3FFF_FFFF, 4'd4},
    '{32'hDEAD_BEEF, 5'd0,  1'b1, 1'b1, 32'hDEAD_BEEF, 4'd5},
    '{32'hFFFF_FFFF, 5'd31, 1'b1, 1'b1, 32'h8000_0000, 4'd2},
    '{32'hA5A5_A5A5, 5'd3,  1'b0, 1'b0, 32'hF4B4_B4B4, 4'd4}
  };

  // Per-bit source lookup, written from the requirements
  function automatic logic [W-1:0] model(input logic [W-1:0] d, input int a,
                                         input logic lft, input logic lgc);
    logic [W-1:0] r;
    logic sgn;
    sgn = (!lft && !lgc) ? d[W-1] : 1'b0;
    for (int j = 0; j < W; j++) begin
      int src;
      src = lft ? j - a : j + a;
      r[j] = (src >= 0 && src < W) ? d[src] : sgn;
    end
    return r;
  endfunction

  task automatic drive(input logic [W-1:0] d, input int a,
                       input logic lft, input logic lgc);
    @(negedge clk);
    data_in = d; amount = a[SW-1:0]; dir_left = lft; mode_logical = lgc;
    #2;
  endtask

  task automatic check(input string req, input logic [W-1:0] exp);
    tests++;
    if (data_out !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (din=%h amt=%0d left=%b logical=%b)",
               req, data_out, exp, data_in, amount, dir_left, mode_logical);
    end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] pats [4];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7E5A_3C19;
    pats[2] = 32'hFFFF_FFFF; pats[3] = 32'hC3A5_0F96;

    // Start state: all-zero inputs give an all-zero word (R5)
    drive('0, 0, 1'b0, 1'b0);
    check("R5 start", '0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].din, int'(VECS[v].amt), VECS[v].lft, VECS[v].lgc);
      check($sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].exp);
    end

    // R2 sweep over every amount, all modes (covers R1 R3 R4 R6)
    foreach (pats[p]) begin
      for (int a = 0; a < W; a++) begin
        for (int m = 0; m < 4; m++) begin
          logic lft, lgc;
          lft = m[1]; lgc = m[0];
          drive(pats[p], a, lft, lgc);
          check(lft ? (lgc ? "R1 sweep" : "R6 sweep")
                    : (lgc ? "R3 sweep" : "R4 sweep"),
                model(pats[p], a, lft, lgc));
        end
      end
    end

    // R5: zero amount in each of the four settings
    for (int m = 0; m < 4; m++) begin
      drive(32'h9BAD_F00D, 0, m[1], m[0]);
      check("R5 zero amount", 32'h9BAD_F00D);
    end

    // R6: arithmetic-left equals logical-left on a negative word
    drive(32'h8765_4321, 12, 1'b1, 1'b0);
    check("R6 arith left", 32'h5432_1000);

    // R7: output follows inputs without any clock edge; no memory of history
    @(negedge clk);
    data_in = 32'h0000_00FF; amount = 5'd8; dir_left = 1'b1; mode_logical = 1'b1;
    #1;
    check("R7 immediate", 32'h0000_FF00);
    data_in = 32'h8000_0000; amount = 5'd1; dir_left = 1'b0; mode_logical = 1'b0;
    #1;
    check("R7 immediate", 32'hC000_0000);
    #1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule